// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Table

Every node on a split-transaction bus keeps one copy of this table. The node watches every request on the address/command bus. Each accepted request is stored under a tag, and the tag travels with the request. The entry stays until a response carrying the same tag appears on the data bus. Responses may return in any order. All nodes see the same bus traffic, so every copy of the table holds the same contents.

The table has a fixed number of slots, eight by default. A new request takes the lowest free slot. The table refuses a bus request with NACK in two cases: when no slot is free, and when the request names a block that already has an outstanding entry. The requester must then retry.

The local node can probe a block address before it asks for the bus, which lets it avoid issuing a request that would conflict. A commit pulse marks the cycle in which one of this node's own ownership requests is accepted. A read-only lookup port returns the contents of any slot by tag.

Top module: `srt_table`

## Requirements
- R1: After rst_ni is released, every slot is empty: valid_o is all zero, full_o is low, and an address-bus request is not NACKed.
- R2: An address-bus request with abus_valid_i high and abus_nack_o low is accepted. It is written into the slot given by abus_tag_o, which is the lowest-numbered free slot. That slot reads back as valid with the request's block address, command, source node and must-respond flag from the next cycle on.
- R3: full_o is high exactly when every slot is valid. While full_o is high, any address-bus request sees abus_nack_o high, and a NACKed request changes no slot.
- R4: A data-bus response (dbus_valid_i high) frees the slot named by dbus_tag_i from the next cycle on, whatever order responses arrive in. A response naming a slot that is not valid has no effect.
- R5: When a request and a freeing response occur in the same cycle, the request is placed using the free slots as they stood before that cycle. The freed slot can be taken only from the following cycle on.
- R6: An address-bus request whose block address equals that of a valid slot is NACKed. No two valid slots ever hold the same block address.
- R7: loc_conflict_o is high exactly when loc_addr_i equals the block address of a valid slot. loc_ok_o equals loc_valid_i and not loc_conflict_o and not full_o.
- R8: commit_o is high in the cycle in which an accepted request has abus_src_i equal to node_id_i and a command of read-exclusive (2'd1) or upgrade (2'd2). Reads (2'd0) and write-backs (2'd3) never raise it.
- R9: The lookup outputs show, in the same cycle, the valid bit and the stored fields of the slot selected by lkp_tag_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| node_id_i | input | NODE_W | Identity of this node |
| abus_valid_i | input | 1 | Request present on the address bus |
| abus_addr_i | input | ADDR_W | Block address of the bus request |
| abus_cmd_i | input | 2 | Command: 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| abus_src_i | input | NODE_W | Node that issued the bus request |
| abus_resp_i | input | 1 | This node must supply the response |
| abus_tag_o | output | TAG_W | Tag given to the request (lowest free slot) |
| abus_nack_o | output | 1 | Request refused, retry later |
| commit_o | output | 1 | Own ownership request committed |
| dbus_valid_i | input | 1 | Response present on the data bus |
| dbus_tag_i | input | TAG_W | Tag carried by the response |
| loc_valid_i | input | 1 | Local node wants to issue a request |
| loc_addr_i | input | ADDR_W | Block address of the local candidate request |
| loc_conflict_o | output | 1 | Candidate block is already outstanding |
| loc_ok_o | output | 1 | Candidate may be issued |
| full_o | output | 1 | All slots valid |
| valid_o | output | NUM_TAGS | Valid bit per slot |
| lkp_tag_i | input | TAG_W | Slot selected for lookup |
| lkp_valid_o | output | 1 | Selected slot is valid |
| lkp_addr_o | output | ADDR_W | Stored block address |
| lkp_cmd_o | output | 2 | Stored command |
| lkp_src_o | output | NODE_W | Stored source node |
| lkp_resp_o | output | 1 | Stored must-respond flag |

## Verification
The assertions check four things on every cycle. A full table always NACKs. An accepted request always lands in a slot that was empty and that slot then becomes valid. A NACK with no response alongside leaves the valid bits alone. No two valid slots hold the same block. Other behaviour shows only across sequences, so the bench's scenarios cover it: the lowest-free-slot order after frees that arrive out of order, a freed slot that stays unusable in the cycle it is released, responses to empty slots being ignored, and stored fields reading back correctly through the lookup port. A reference model predicts every output each cycle, both under directed fill and drain and under long pseudo-random traffic with many address collisions.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_UPG = 2'd2,
    CMD_WB  = 2'd3
  } srt_cmd_e;

  function automatic logic is_ownership(logic [1:0] c);
    return (c == CMD_RDX) || (c == CMD_UPG);
  endfunction
endpackage

// File: rtl/srt_free_pick.sv
module srt_free_pick #(
  parameter int N     = 8,
  parameter int TAG_W = $clog2(N)
) (
  input  logic [N-1:0]     busy_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             any_o
);
  // descending scan so the lowest free index wins
  always_comb begin
    tag_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        tag_o = TAG_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/srt_match.sv
module srt_match #(
  parameter int N      = 8,
  parameter int ADDR_W = 26
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0]               valid_i,
  input  logic [N-1:0][ADDR_W-1:0]   addr_i,
  input  logic [ADDR_W-1:0]          probe_i,
  output logic [N-1:0]               hit_vec_o,
  output logic                       hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec_o[i] = valid_i[i] && (addr_i[i] == probe_i);
  end
  assign hit_o = |hit_vec_o;

  AST_UNIQUE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o)); // R6
endmodule

// File: rtl/srt_store.sv
module srt_store #(
  parameter int N      = 8,
  parameter int ADDR_W = 26,
  parameter int NODE_W = 4,
  parameter int TAG_W  = $clog2(N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     alloc_en_i,
  input  logic [TAG_W-1:0]         alloc_tag_i,
  input  logic [ADDR_W-1:0]        alloc_addr_i,
  input  logic [1:0]               alloc_cmd_i,
  input  logic [NODE_W-1:0]        alloc_src_i,
  input  logic                     alloc_resp_i,
  input  logic                     free_en_i,
  input  logic [TAG_W-1:0]         free_tag_i,
  output logic [N-1:0]             valid_o,
  output logic [N-1:0][ADDR_W-1:0] addr_o,
  output logic [N-1:0][1:0]        cmd_o,
  output logic [N-1:0][NODE_W-1:0] src_o,
  output logic [N-1:0]             resp_o
);
  logic [N-1:0] valid_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic set_w, clr_w;
    assign set_w = alloc_en_i && (alloc_tag_i == TAG_W'(i));
    assign clr_w = free_en_i && (free_tag_i == TAG_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
      end else if (set_w) begin
        valid_q[i] <= 1'b1;
      end else if (clr_w) begin
        valid_q[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o[i] <= '0;
        cmd_o[i]  <= '0;
        src_o[i]  <= '0;
        resp_o[i] <= 1'b0;
      end else if (set_w) begin
        addr_o[i] <= alloc_addr_i;
        cmd_o[i]  <= alloc_cmd_i;
        src_o[i]  <= alloc_src_i;
        resp_o[i] <= alloc_resp_i;
      end
    end
  end

  assign valid_o = valid_q;

  AST_FREE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_en_i && !(alloc_en_i && alloc_tag_i == free_tag_i))
      |=> !valid_q[$past(free_tag_i)]); // R4
  AST_ALLOC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |=> valid_q[$past(alloc_tag_i)]); // R2
endmodule

// File: rtl/srt_table.sv
module srt_table
  import srt_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int ADDR_W   = 26,
  parameter int NODE_W   = 4,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NODE_W-1:0]   node_id_i,
  input  logic                abus_valid_i,
  input  logic [ADDR_W-1:0]   abus_addr_i,
  input  logic [1:0]          abus_cmd_i,
  input  logic [NODE_W-1:0]   abus_src_i,
  input  logic                abus_resp_i,
  output logic [TAG_W-1:0]    abus_tag_o,
  output logic                abus_nack_o,
  output logic                commit_o,
  input  logic                dbus_valid_i,
  input  logic [TAG_W-1:0]    dbus_tag_i,
  input  logic                loc_valid_i,
  input  logic [ADDR_W-1:0]   loc_addr_i,
  output logic                loc_conflict_o,
  output logic                loc_ok_o,
  output logic                full_o,
  output logic [NUM_TAGS-1:0] valid_o,
  input  logic [TAG_W-1:0]    lkp_tag_i,
  output logic                lkp_valid_o,
  output logic [ADDR_W-1:0]   lkp_addr_o,
  output logic [1:0]          lkp_cmd_o,
  output logic [NODE_W-1:0]   lkp_src_o,
  output logic                lkp_resp_o
);
  logic [NUM_TAGS-1:0]             valid_w;
  logic [NUM_TAGS-1:0][ADDR_W-1:0] addr_w;
  logic [NUM_TAGS-1:0][1:0]        cmd_w;
  logic [NUM_TAGS-1:0][NODE_W-1:0] src_w;
  logic [NUM_TAGS-1:0]             resp_w;
  logic [NUM_TAGS-1:0]             bus_hits_w, loc_hits_w;
  logic                            bus_hit_w, any_free_w, accept_w;
  logic [TAG_W-1:0]                free_tag_w;

  srt_free_pick #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_pick (
    .busy_i (valid_w),
    .tag_o  (free_tag_w),
    .any_o  (any_free_w)
  );

  srt_match #(.N(NUM_TAGS), .ADDR_W(ADDR_W)) u_bus_match (
    .clk_i, .rst_ni,
    .valid_i   (valid_w),
    .addr_i    (addr_w),
    .probe_i   (abus_addr_i),
    .hit_vec_o (bus_hits_w),
    .hit_o     (bus_hit_w)
  );

  srt_match #(.N(NUM_TAGS), .ADDR_W(ADDR_W)) u_loc_match (
    .clk_i, .rst_ni,
    .valid_i   (valid_w),
    .addr_i    (addr_w),
    .probe_i   (loc_addr_i),
    .hit_vec_o (loc_hits_w),
    .hit_o     (loc_conflict_o)
  );

  // refuse on no space or on a block already in flight
  assign full_o      = !any_free_w;
  assign abus_nack_o = abus_valid_i && (full_o || bus_hit_w);
  assign accept_w    = abus_valid_i && !abus_nack_o;
  assign abus_tag_o  = free_tag_w;
  assign commit_o    = accept_w && (abus_src_i == node_id_i) && is_ownership(abus_cmd_i);
  assign loc_ok_o    = loc_valid_i && !loc_conflict_o && !full_o;

  srt_store #(.N(NUM_TAGS), .ADDR_W(ADDR_W), .NODE_W(NODE_W), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .alloc_en_i   (accept_w),
    .alloc_tag_i  (free_tag_w),
    .alloc_addr_i (abus_addr_i),
    .alloc_cmd_i  (abus_cmd_i),
    .alloc_src_i  (abus_src_i),
    .alloc_resp_i (abus_resp_i),
    .free_en_i    (dbus_valid_i),
    .free_tag_i   (dbus_tag_i),
    .valid_o      (valid_w),
    .addr_o       (addr_w),
    .cmd_o        (cmd_w),
    .src_o        (src_w),
    .resp_o       (resp_w)
  );

  assign valid_o     = valid_w;
  assign lkp_valid_o = valid_w[lkp_tag_i];
  assign lkp_addr_o  = addr_w[lkp_tag_i];
  assign lkp_cmd_o   = cmd_w[lkp_tag_i];
  assign lkp_src_o   = src_w[lkp_tag_i];
  assign lkp_resp_o  = resp_w[lkp_tag_i];

  AST_FULL_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abus_valid_i && (&valid_o)) |-> abus_nack_o); // R3
  AST_ALLOC_EMPTY_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abus_valid_i && !abus_nack_o) |-> !valid_o[abus_tag_o]); // R2
  AST_NACK_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abus_nack_o && !dbus_valid_i) |=> $stable(valid_o)); // R3
  AST_COMMIT_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (abus_valid_i && !abus_nack_o)); // R8
endmodule

// File: tb/tb_srt_table.sv
module tb_srt_table;
  localparam int N = 8, AW = 26, NW = 4, TW = 3;

  logic clk = 0, rst_ni = 0;
  logic [NW-1:0] node_id = 4'd5;
  logic abus_valid = 0, abus_resp = 0, dbus_valid = 0, loc_valid = 0;
  logic [AW-1:0] abus_addr = 0, loc_addr = 0;
  logic [1:0] abus_cmd = 0;
  logic [NW-1:0] abus_src = 0;
  logic [TW-1:0] dbus_tag = 0, lkp_tag = 0;
  logic [TW-1:0] abus_tag;
  logic abus_nack, commit, loc_conflict, loc_ok, full, lkp_valid, lkp_resp;
  logic [N-1:0] valid;
  logic [AW-1:0] lkp_addr;
  logic [1:0] lkp_cmd;
  logic [NW-1:0] lkp_src;

  srt_table dut (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(node_id),
    .abus_valid_i(abus_valid), .abus_addr_i(abus_addr), .abus_cmd_i(abus_cmd),
    .abus_src_i(abus_src), .abus_resp_i(abus_resp), .abus_tag_o(abus_tag),
    .abus_nack_o(abus_nack), .commit_o(commit),
    .dbus_valid_i(dbus_valid), .dbus_tag_i(dbus_tag),
    .loc_valid_i(loc_valid), .loc_addr_i(loc_addr),
    .loc_conflict_o(loc_conflict), .loc_ok_o(loc_ok),
    .full_o(full), .valid_o(valid), .lkp_tag_i(lkp_tag),
    .lkp_valid_o(lkp_valid), .lkp_addr_o(lkp_addr), .lkp_cmd_o(lkp_cmd),
    .lkp_src_o(lkp_src), .lkp_resp_o(lkp_resp)
  );

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference model
  bit        m_v[N];
  bit [AW-1:0] m_a[N];
  bit [1:0]  m_c[N];
  bit [NW-1:0] m_s[N];
  bit        m_r[N];

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  function automatic bit hit(bit [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return 1;
    return 0;
  endfunction

  // inputs are set at negedge; compare, then advance the model at posedge
  task automatic cycle();
    int  lf;
    bit  e_full, e_nack, e_acc, e_conf;
    bit [N-1:0] e_valid;
    #1;
    lf = lowest_free();
    e_full = (lf < 0);
    e_nack = abus_valid && (e_full || hit(abus_addr));
    e_acc  = abus_valid && !e_nack;
    e_conf = hit(loc_addr);
    for (int i = 0; i < N; i++) e_valid[i] = m_v[i];
    chk("R3", "full", full, e_full);
    chk("R3", "valid", valid, e_valid);
    chk("R6", "nack", abus_nack, e_nack);
    if (!e_full) chk("R2", "tag", abus_tag, lf);
    chk("R8", "commit", commit, e_acc && abus_src == node_id && (abus_cmd == 2'd1 || abus_cmd == 2'd2));
    chk("R7", "conflict", loc_conflict, e_conf);
    chk("R7", "loc_ok", loc_ok, loc_valid && !e_conf && !e_full);
    chk("R9", "lkp_valid", lkp_valid, m_v[lkp_tag]);
    if (m_v[lkp_tag]) begin
      chk("R9", "lkp_addr", lkp_addr, m_a[lkp_tag]);
      chk("R9", "lkp_cmd", lkp_cmd, m_c[lkp_tag]);
      chk("R9", "lkp_src", lkp_src, m_s[lkp_tag]);
      chk("R9", "lkp_resp", lkp_resp, m_r[lkp_tag]);
    end
    @(posedge clk);
    // R4: frees apply to valid slots only; R5: allocation used pre-cycle state
    if (dbus_valid && m_v[dbus_tag]) m_v[dbus_tag] = 0;
    if (e_acc) begin
      m_v[lf] = 1; m_a[lf] = abus_addr; m_c[lf] = abus_cmd;
      m_s[lf] = abus_src; m_r[lf] = abus_resp;
    end
    @(negedge clk);
    lkp_tag = lkp_tag + 1;
  endtask

  task automatic idle();
    abus_valid = 0; dbus_valid = 0; loc_valid = 0;
  endtask

  task automatic req(bit [AW-1:0] a, bit [1:0] c, bit [NW-1:0] s, bit r);
    abus_valid = 1; abus_addr = a; abus_cmd = c; abus_src = s; abus_resp = r;
  endtask

  task automatic rsp(bit [TW-1:0] t);
    dbus_valid = 1; dbus_tag = t;
  endtask

  bit [31:0] lfsr = 32'hACE1_1234;
  function automatic bit [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1", "reset_full", full, 0);
    chk("R1", "reset_valid", valid, 0);
    rst_ni = 1;
    @(negedge clk);
    idle(); cycle();
    req(26'h40, 2'd0, 4'd2, 0); cycle();          // R1: first request accepted at tag 0
    idle(); rsp(3'd0); cycle();
    idle();
    // R2/R8: fill all slots, own node, mixed commands
    for (int i = 0; i < N; i++) begin
      req(26'h100 + i, 2'(i), (i % 2) ? node_id : 4'd1, i[0]);
      cycle();
    end
    idle();
    req(26'h200, 2'd1, node_id, 0); cycle();      // R3: full -> nack, no commit
    idle();
    // R4: out-of-order frees
    rsp(3'd5); cycle();
    rsp(3'd2); cycle();
    idle();
    req(26'h300, 2'd2, node_id, 1); cycle();      // R2: lowest free -> 2
    req(26'h301, 2'd0, 4'd3, 0); cycle();         // R2: next -> 5
    // R5: free and request same cycle while full
    idle(); req(26'h302, 2'd1, node_id, 0); rsp(3'd3); cycle();
    idle(); req(26'h302, 2'd1, node_id, 0); cycle(); // now lands in 3
    // R6: duplicate block refused
    idle(); rsp(3'd0); cycle();
    idle(); req(26'h302, 2'd0, 4'd4, 0); cycle();
    // R4: response to empty slot ignored
    idle(); rsp(3'd0); cycle();
    idle(); cycle();
    // R7: local probe
    loc_valid = 1; loc_addr = 26'h301; cycle();
    loc_addr = 26'h999; cycle();
    idle();
    // random traffic with small address pool
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] r;
      r = rnd();
      abus_valid = (r[3:0] < 10);
      abus_addr  = 26'h500 + 26'(r[7:4] % 12);
      abus_cmd   = r[9:8];
      abus_src   = r[10] ? node_id : 4'(r[14:11]);
      abus_resp  = r[15];
      dbus_valid = (r[19:16] < 7);
      dbus_tag   = r[22:20];
      loc_valid  = r[23];
      loc_addr   = 26'h500 + 26'(r[27:24] % 12);
      cycle();
    end
    idle();
    for (int t = 0; t < N; t++) begin rsp(TW'(t)); cycle(); end
    idle(); cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule